// File: doc/BRIEF.md
# Resistance-to-Frequency Conversion Counter

This block turns an unknown resistance into a number. An external RC oscillator's clock arrives as a digital input. The block counts its cycles in a measurement counter while a second counter, the time-base counter, advances on a reference tick. Both counters are `W` bits wide (default 20) and count upward. The end of a conversion is the carry out of the top bit of either counter. That carry stops the conversion in the same clock edge, and a flag that belongs to that counter is set and stays set.

A conversion is used in two phases. In the reference phase (`phase_sel_i` = 0), the measurement counter is preset to 2^W minus a chosen cycle count, and the time-base counter starts at zero. The phase ends when the measurement counter wraps, and the time-base count then records how long the reference resistor took. In the sensor phase (`phase_sel_i` = 1), the time-base counter is preloaded with that recorded value and the phase ends when it wraps back to zero. The measurement counter then holds the sensor's cycle count. An overflow of the counter that was not meant to end the phase shows up in its own flag, and software treats the result as invalid.

There is no data stream here. The results are held in registers until the next start, so there is no valid/ready handshake and no back-pressure. Every control and status pin is a plain level or pulse.

Top module: `rfc_top`

## Requirements
- R1: After reset, `busy_o`, `done_o`, `mc_ovf_o` and `tbc_ovf_o` are 0, and both counter values are 0.
- R2: A cycle with `start_i`=1 while idle does the following at the next edge: it loads the measurement counter with `mc_init_i`, loads the time-base counter with 0 when `phase_sel_i`=0 or with `tb_init_i` when `phase_sel_i`=1, clears both overflow flags and raises `busy_o`.
- R3: While busy, each rising edge of `cr_clk_i` adds one to the measurement counter. The edge is seen through a two-flop synchroniser, and `cr_clk_i` must hold each level for at least two clock cycles.
- R4: While busy, each clock cycle with `tb_tick_i`=1 adds one to the time-base counter.
- R5: A measurement-counter increment from all ones wraps it to 0, sets `mc_ovf_o` and ends the conversion at that same edge. `mc_ovf_o` then stays set until the next accepted start.
- R6: A time-base-counter increment from all ones wraps it to 0, sets `tbc_ovf_o` and ends the conversion at that same edge. `tbc_ovf_o` then stays set until the next accepted start.
- R7: Each conversion produces exactly one single-cycle `done_o` pulse. The pulse falls in the first cycle where `busy_o` is 0.
- R8: `start_i` while busy has no effect. The counters keep counting from their current values, and the new preset and phase inputs are ignored.
- R9: While idle, `cr_clk_i` edges and `tb_tick_i` leave both counter values and both flags unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start request, honoured only while idle |
| phase_sel_i | input | 1 | 0 = reference phase, 1 = sensor phase |
| mc_init_i | input | W | Measurement counter preset |
| tb_init_i | input | W | Time-base preset, used in the sensor phase |
| cr_clk_i | input | 1 | Asynchronous RC oscillator clock |
| tb_tick_i | input | 1 | Time-base count enable, one count per high cycle |
| busy_o | output | 1 | Conversion in progress |
| done_o | output | 1 | One-cycle pulse at the end of a conversion |
| mc_value_o | output | W | Measurement counter value |
| tbc_value_o | output | W | Time-base counter value |
| mc_ovf_o | output | 1 | Sticky measurement-counter overflow flag |
| tbc_ovf_o | output | 1 | Sticky time-base-counter overflow flag |

## Verification
The checks assume that `cr_clk_i` holds each level for at least two clock cycles, so that no edge is lost in the synchroniser. They also assume that `tb_tick_i` and `start_i` are synchronous to `clk`. The stimulus holds the oscillator input high for three cycles and low for three cycles. It drives time-base ticks only while that input is low, so every tick lands well clear of the instant at which an oscillator edge is counted. It changes every input on the falling clock edge.

// File: rtl/rfc_pkg.sv
package rfc_pkg;
  localparam int unsigned RFC_W_DEF = 20;

  typedef enum logic {
    PH_REF   = 1'b0,
    PH_SENSE = 1'b1
  } rfc_phase_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } rfc_state_e;
endpackage

// File: rtl/rfc_edge_sync.sv
module rfc_edge_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_i,
  output logic rise_o
);
  localparam int unsigned LAST = STAGES - 1;

  logic [STAGES-1:0] chain_q;
  logic              prev_q;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q[i] <= 1'b0;
        else        chain_q[i] <= async_i;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q[i] <= 1'b0;
        else        chain_q[i] <= chain_q[i-1];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= chain_q[LAST];
  end

  assign rise_o = chain_q[LAST] & ~prev_q;
endmodule

// File: rtl/rfc_upcnt.sv
module rfc_upcnt #(
  parameter int unsigned W = 20
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  input  logic         inc_i,
  output logic [W-1:0] val_o,
  output logic         carry_o
);
  localparam logic [W-1:0] ONE = W'(1);

  logic [W-1:0] val_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      val_q <= '0;
    else if (load_i) val_q <= load_val_i;
    else if (inc_i)  val_q <= val_q + ONE;
  end

  // carry out of the top bit: an increment applied to an all-ones value
  assign carry_o = inc_i & (&val_q);
  assign val_o   = val_q;
endmodule

// File: rtl/rfc_ctrl.sv
module rfc_ctrl
  import rfc_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic mc_carry_i,
  input  logic tb_carry_i,
  output logic busy_o,
  output logic load_o,
  output logic done_o,
  output logic mc_ovf_o,
  output logic tb_ovf_o
);
  rfc_state_e st_q;
  logic       fin;

  assign busy_o = (st_q == ST_RUN);
  assign load_o = start_i & ~busy_o;
  assign fin    = busy_o & (mc_carry_i | tb_carry_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= ST_IDLE;
      done_o   <= 1'b0;
      mc_ovf_o <= 1'b0;
      tb_ovf_o <= 1'b0;
    end else begin
      done_o <= fin;
      unique case (st_q)
        ST_IDLE: if (start_i) st_q <= ST_RUN;
        ST_RUN:  if (fin)     st_q <= ST_IDLE;
        default:              st_q <= ST_IDLE;
      endcase
      if (load_o) begin
        mc_ovf_o <= 1'b0;
        tb_ovf_o <= 1'b0;
      end else begin
        if (busy_o && mc_carry_i) mc_ovf_o <= 1'b1;
        if (busy_o && tb_carry_i) tb_ovf_o <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/rfc_top.sv
module rfc_top
  import rfc_pkg::*;
#(
  parameter int unsigned W           = RFC_W_DEF,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start_i,
  input  logic         phase_sel_i,
  input  logic [W-1:0] mc_init_i,
  input  logic [W-1:0] tb_init_i,
  input  logic         cr_clk_i,
  input  logic         tb_tick_i,
  output logic         busy_o,
  output logic         done_o,
  output logic [W-1:0] mc_value_o,
  output logic [W-1:0] tbc_value_o,
  output logic         mc_ovf_o,
  output logic         tbc_ovf_o
);
  rfc_phase_e   phase;
  logic         cr_rise;
  logic         load;
  logic         mc_carry;
  logic         tb_carry;
  logic [W-1:0] tb_preset;

  assign phase     = rfc_phase_e'(phase_sel_i);
  assign tb_preset = (phase == PH_SENSE) ? tb_init_i : '0;

  rfc_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i (cr_clk_i),
    .rise_o  (cr_rise)
  );

  rfc_upcnt #(.W(W)) u_mc (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (load),
    .load_val_i (mc_init_i),
    .inc_i      (busy_o & cr_rise),
    .val_o      (mc_value_o),
    .carry_o    (mc_carry)
  );

  rfc_upcnt #(.W(W)) u_tbc (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (load),
    .load_val_i (tb_preset),
    .inc_i      (busy_o & tb_tick_i),
    .val_o      (tbc_value_o),
    .carry_o    (tb_carry)
  );

  rfc_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .mc_carry_i (mc_carry),
    .tb_carry_i (tb_carry),
    .busy_o     (busy_o),
    .load_o     (load),
    .done_o     (done_o),
    .mc_ovf_o   (mc_ovf_o),
    .tb_ovf_o   (tbc_ovf_o)
  );
endmodule

// File: rtl/rfc_chk.sv
module rfc_chk #(
  parameter int unsigned W = 20
) (
  input logic         clk,
  input logic         rst_n,
  input logic         start_i,
  input logic         tb_tick_i,
  input logic [W-1:0] mc_init_i,
  input logic         busy_o,
  input logic         done_o,
  input logic [W-1:0] mc_value_o,
  input logic [W-1:0] tbc_value_o,
  input logic         mc_ovf_o,
  input logic         tbc_ovf_o
);
  // R2
  start_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && start_i) |=> (busy_o && !mc_ovf_o && !tbc_ovf_o && mc_value_o == $past(mc_init_i)));

  // R4
  tb_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && tb_tick_i) |=> (tbc_value_o == $past(tbc_value_o) + W'(1)));

  // R5
  mc_ovf_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mc_ovf_o) |-> (mc_value_o == '0 && !busy_o));

  // R5
  mc_ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mc_ovf_o && !(start_i && !busy_o)) |=> mc_ovf_o);

  // R6
  tb_ovf_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tbc_ovf_o) |-> (tbc_value_o == '0 && !busy_o));

  // R7
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R7
  done_at_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> done_o);

  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && !start_i) |=> ($stable(mc_value_o) && $stable(tbc_value_o)));
endmodule

bind rfc_top rfc_chk #(.W(W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .start_i     (start_i),
  .tb_tick_i   (tb_tick_i),
  .mc_init_i   (mc_init_i),
  .busy_o      (busy_o),
  .done_o      (done_o),
  .mc_value_o  (mc_value_o),
  .tbc_value_o (tbc_value_o),
  .mc_ovf_o    (mc_ovf_o),
  .tbc_ovf_o   (tbc_ovf_o)
);

// File: tb/rfc_top_tb.sv
module rfc_top_tb;
  localparam int unsigned W     = 8;
  localparam int          STEPS = 12;
  localparam int          NVEC  = 8;

  typedef struct packed {
    logic         phase;
    logic [W-1:0] mc_init;
    logic [W-1:0] tb_init;
    logic [7:0]   k;
    logic [W-1:0] exp_mc;
    logic [W-1:0] exp_tb;
    logic         exp_omc;
    logic         exp_otb;
  } vec_t;

  // each step: k ticks, then one oscillator pulse (3 high, 3 low)
  localparam vec_t VEC [NVEC] = '{
    '{1'b0, 8'd251, 8'd200, 8'd4,  8'd0,   8'd20,  1'b1, 1'b0},
    '{1'b0, 8'd246, 8'd17,  8'd7,  8'd0,   8'd70,  1'b1, 1'b0},
    '{1'b0, 8'd246, 8'd0,   8'd30, 8'd254, 8'd0,   1'b0, 1'b1},
    '{1'b1, 8'd0,   8'd236, 8'd4,  8'd4,   8'd0,   1'b0, 1'b1},
    '{1'b1, 8'd100, 8'd223, 8'd3,  8'd110, 8'd0,   1'b0, 1'b1},
    '{1'b1, 8'd253, 8'd156, 8'd5,  8'd0,   8'd171, 1'b1, 1'b0},
    '{1'b0, 8'd255, 8'd9,   8'd0,  8'd0,   8'd0,   1'b1, 1'b0},
    '{1'b1, 8'd7,   8'd255, 8'd2,  8'd7,   8'd0,   1'b0, 1'b1}
  };

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start_i = 1'b0;
  logic         phase_sel_i = 1'b0;
  logic [W-1:0] mc_init_i = '0;
  logic [W-1:0] tb_init_i = '0;
  logic         cr_clk_i = 1'b0;
  logic         tb_tick_i = 1'b0;
  logic         busy_o, done_o, mc_ovf_o, tbc_ovf_o;
  logic [W-1:0] mc_value_o, tbc_value_o;

  int n_tests = 0;
  int n_fail  = 0;
  int done_cnt = 0;

  always #5 clk = ~clk;

  rfc_top #(.W(W)) u_dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .phase_sel_i (phase_sel_i),
    .mc_init_i   (mc_init_i),
    .tb_init_i   (tb_init_i),
    .cr_clk_i    (cr_clk_i),
    .tb_tick_i   (tb_tick_i),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .mc_value_o  (mc_value_o),
    .tbc_value_o (tbc_value_o),
    .mc_ovf_o    (mc_ovf_o),
    .tbc_ovf_o   (tbc_ovf_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic tick_burst(input int k);
    if (k > 0) begin
      tb_tick_i = 1'b1;
      cyc(k);
      tb_tick_i = 1'b0;
    end
  endtask

  task automatic cr_pulse();
    cr_clk_i = 1'b1;
    cyc(3);
    cr_clk_i = 1'b0;
    cyc(3);
  endtask

  task automatic do_start(input logic ph, input logic [W-1:0] mi, input logic [W-1:0] ti);
    phase_sel_i = ph;
    mc_init_i   = mi;
    tb_init_i   = ti;
    start_i     = 1'b1;
    cyc(1);
    start_i     = 1'b0;
  endtask

  // R7: done pulses only when busy has already dropped
  always @(negedge clk) begin
    if (rst_n && done_o) begin
      done_cnt++;
      chk(!busy_o, "R7 done with busy low", int'(busy_o), 0);
    end
  end

  initial begin
    #1_000_000;
    n_tests++;
    n_fail++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    cyc(3);
    // R1: reset state
    chk(!busy_o && !done_o, "R1 busy/done at reset", int'({busy_o, done_o}), 0);
    chk(!mc_ovf_o && !tbc_ovf_o, "R1 flags at reset", int'({mc_ovf_o, tbc_ovf_o}), 0);
    chk(mc_value_o == 0 && tbc_value_o == 0, "R1 counters at reset",
        int'(mc_value_o) + int'(tbc_value_o), 0);
    rst_n = 1'b1;
    cyc(2);

    for (int v = 0; v < NVEC; v++) begin
      done_cnt = 0;
      do_start(VEC[v].phase, VEC[v].mc_init, VEC[v].tb_init);
      // R2: preset load, flags cleared, busy raised
      chk(busy_o && !mc_ovf_o && !tbc_ovf_o, "R2 busy set, flags clear",
          int'({busy_o, mc_ovf_o, tbc_ovf_o}), 4);
      chk(mc_value_o == VEC[v].mc_init, "R2 mc preset", int'(mc_value_o), int'(VEC[v].mc_init));
      chk(tbc_value_o == (VEC[v].phase ? VEC[v].tb_init : '0), "R2 tbc preset by phase",
          int'(tbc_value_o), VEC[v].phase ? int'(VEC[v].tb_init) : 0);
      for (int s = 0; s < STEPS; s++) begin
        tick_burst(int'(VEC[v].k));
        cr_pulse();
      end
      cyc(4);
      // R3 R4: counts; R5 R6: wrap and flags
      chk(mc_value_o == VEC[v].exp_mc, "R3 R5 mc result", int'(mc_value_o), int'(VEC[v].exp_mc));
      chk(tbc_value_o == VEC[v].exp_tb, "R4 R6 tbc result", int'(tbc_value_o), int'(VEC[v].exp_tb));
      chk(mc_ovf_o == VEC[v].exp_omc, "R5 mc overflow flag", int'(mc_ovf_o), int'(VEC[v].exp_omc));
      chk(tbc_ovf_o == VEC[v].exp_otb, "R6 tbc overflow flag", int'(tbc_ovf_o), int'(VEC[v].exp_otb));
      chk(!busy_o && done_cnt == 1, "R7 one done per conversion", done_cnt, 1);
      // R9: idle stimulus changes nothing
      tick_burst(3);
      cr_pulse();
      cyc(3);
      chk(mc_value_o == VEC[v].exp_mc && tbc_value_o == VEC[v].exp_tb, "R9 idle hold counters",
          int'(mc_value_o), int'(VEC[v].exp_mc));
      chk(mc_ovf_o == VEC[v].exp_omc && tbc_ovf_o == VEC[v].exp_otb, "R9 idle hold flags",
          int'({mc_ovf_o, tbc_ovf_o}), int'({VEC[v].exp_omc, VEC[v].exp_otb}));
    end

    // R8: restart while busy is ignored
    done_cnt = 0;
    do_start(1'b0, 8'd250, 8'd0);
    for (int s = 0; s < 2; s++) begin
      tick_burst(2);
      cr_pulse();
    end
    do_start(1'b1, 8'd0, 8'd5);
    chk(busy_o, "R8 still busy after ignored start", int'(busy_o), 1);
    chk(mc_value_o == 8'd252 && tbc_value_o == 8'd4, "R8 counts kept after ignored start",
        int'(mc_value_o), 252);
    for (int s = 0; s < 10; s++) begin
      tick_burst(2);
      cr_pulse();
    end
    cyc(4);
    chk(mc_value_o == 8'd0 && tbc_value_o == 8'd12, "R8 result unaffected by ignored start",
        int'(tbc_value_o), 12);
    chk(mc_ovf_o && !tbc_ovf_o && done_cnt == 1, "R8 R5 flags and done",
        int'({mc_ovf_o, tbc_ovf_o}), 2);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule